// File: doc/BRIEF.md
# Multi-target level interrupt router

This block gathers level-sensitive interrupt requests from a configurable set of sources and steers them to a configurable set of targets, such as processor harts or privilege contexts. Each source carries a programmable priority. Each target carries a programmable threshold and its own mask of enabled sources. A target's interrupt line is high while at least one source is pending, enabled for it and ranked strictly above its threshold.

Software sets priorities, masks and thresholds, and reads the pending set, through a small shared configuration port. Each target also has a private claim/complete port. A claim strobe returns the best eligible source for that target and moves the source from pending to in-service. A completion write naming that source takes it out of service, after which a request line that is still high makes it pending again. Source numbers run from 1 upward. Number 0 means "nothing" and is what an empty claim returns.

Top module: `irq_router`

## Requirements
- R1: After reset, every priority, enable mask, threshold, pending bit and in-service bit is zero, every `tgt_irq` output is low, and a claim returns 0.
- R2: Configuration map (byte address, `cfg_addr[8:7]` selects the region, `cfg_addr[6:2]` the index): priority of source k at 4*k (region 0), pending word at 0x080 with bit k for source k (region 1), enable mask of target t at 0x100+4*t with bit k for source k (region 2), threshold of target t at 0x180+4*t (region 3). Read data appears on `cfg_rdata` one clock edge after `cfg_rd`. Priority and threshold keep only their low PRIO_W bits, upper bits read 0, and bit 0 of an enable mask always reads 0.
- R3: `tgt_irq[t]` is high exactly when some source is pending, enabled for t, and has a priority strictly greater than t's threshold. A request seen at a clock edge makes the source pending at that edge.
- R4: Clearing a source's enable bit for one target keeps that target's line low without affecting other targets on which it is enabled.
- R5: A claim strobe on target t returns, on `clm_rid` one edge later, the winning source for t and clears its pending bit at that edge. With nothing eligible it returns 0.
- R6: When several targets claim the same winning source at the same edge, the lowest-numbered target receives it and the others read 0.
- R7: A claimed source does not become pending again, even with its request held high, until it is completed. After completion, a held request makes it pending one edge later.
- R8: A completion naming source 0, a number above the source count, or a source not in service changes nothing.
- R9: Among eligible sources the highest priority wins. On equal priority the lowest source number wins.
- R10: A source with priority 0 never drives a target line and is never returned by a claim, though it may be pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | N_SRC | Level requests. Bit k-1 belongs to source k |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 9 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one edge after `cfg_rd` |
| clm_rd | input | N_TGT | Per-target claim strobe |
| clm_wr | input | N_TGT | Per-target completion strobe |
| clm_wid | input | N_TGT*ID_W | Per-target completed source number, target t at bits t*ID_W |
| clm_rid | output | N_TGT*ID_W | Per-target claimed source number, one edge after `clm_rd` |
| tgt_irq | output | N_TGT | Per-target interrupt line |

## Verification
The assertions take for granted that configuration strobes address only mapped words and that a completion is issued by software that claimed earlier. They check uniqueness of grants and the exclusion of pending and in-service states under any claim pattern, including overlapping claims from several targets. The directed stimulus changes request lines and strobes only at the falling edge and holds each strobe for exactly one cycle, so every claim and completion is counted once. It deliberately issues stray completions, with numbers out of range and of sources not in service, to show they leave state untouched.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int REG_W  = 32;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = 9;

  typedef enum logic [1:0] {
    RG_PRIO = 2'd0,
    RG_PEND = 2'd1,
    RG_EN   = 2'd2,
    RG_THR  = 2'd3
  } region_e;
endpackage

// File: rtl/irq_src_state.sv
module irq_src_state #(
  parameter int N_SRC = 31
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_SRC:1] req,
  input  logic [N_SRC:0] take,
  input  logic [N_SRC:0] done,
  output logic [N_SRC:0] pend,
  output logic [N_SRC:0] busy
);
  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;

  for (genvar i = 1; i <= N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[i] <= 1'b0;
        busy[i] <= 1'b0;
      end else begin
        pend[i] <= take[i] ? 1'b0 : (pend[i] | (req[i] & ~busy[i]));
        busy[i] <= take[i] ? 1'b1 : (busy[i] & ~done[i]);
      end
    end
  end
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel #(
  parameter int N_SRC  = 31,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 5
) (
  input  logic [N_SRC:0]             pend,
  input  logic [N_SRC:0]             en,
  input  logic [N_SRC:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]          thr,
  output logic [ID_W-1:0]            best_id
);
  // Strict compare against a running best that starts at the threshold:
  // gives "above threshold", "highest wins" and "lowest id on ties" at once.
  function automatic logic [ID_W-1:0] pick(
    input logic [N_SRC:0]             p,
    input logic [N_SRC:0]             e,
    input logic [N_SRC:0][PRIO_W-1:0] pr,
    input logic [PRIO_W-1:0]          th
  );
    logic [PRIO_W-1:0] bp;
    logic [ID_W-1:0]   bid;
    bp  = th;
    bid = '0;
    for (int i = 1; i <= N_SRC; i++) begin
      if (p[i] && e[i] && (pr[i] > bp)) begin
        bp  = pr[i];
        bid = ID_W'(i);
      end
    end
    return bid;
  endfunction

  assign best_id = pick(pend, en, prio, thr);
endmodule

// File: rtl/irq_claim_arb.sv
module irq_claim_arb #(
  parameter int N_SRC = 31,
  parameter int N_TGT = 2,
  parameter int ID_W  = 5
) (
  input  logic [N_TGT*ID_W-1:0] best_flat,
  input  logic [N_TGT-1:0]      clm_rd,
  output logic [N_TGT*ID_W-1:0] grant_flat,
  output logic [N_SRC:0]        take
);
  always_comb begin
    logic [ID_W-1:0] cand;
    take       = '0;
    grant_flat = '0;
    for (int t = 0; t < N_TGT; t++) begin
      cand = best_flat[t*ID_W +: ID_W];
      if (clm_rd[t] && (cand != '0) && !take[cand]) begin
        take[cand]                = 1'b1;
        grant_flat[t*ID_W +: ID_W] = cand;
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_SRC  = 31,
  parameter int N_TGT  = 2,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(N_SRC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       irq_i,
  input  logic                   cfg_wr,
  input  logic                   cfg_rd,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [REG_W-1:0]       cfg_wdata,
  output logic [REG_W-1:0]       cfg_rdata,
  input  logic [N_TGT-1:0]       clm_rd,
  input  logic [N_TGT-1:0]       clm_wr,
  input  logic [N_TGT*ID_W-1:0]  clm_wid,
  output logic [N_TGT*ID_W-1:0]  clm_rid,
  output logic [N_TGT-1:0]       tgt_irq
);
  logic [N_SRC:0][PRIO_W-1:0]    prio_q;
  logic [N_TGT-1:0][N_SRC:0]     en_q;
  logic [N_TGT-1:0][PRIO_W-1:0]  thr_q;

  logic [N_SRC:0]                pend;
  logic [N_SRC:0]                busy;
  logic [N_SRC:0]                take;
  logic [N_SRC:0]                done;
  logic [N_TGT*ID_W-1:0]         best_flat;
  logic [N_TGT*ID_W-1:0]         grant_flat;
  logic [N_TGT-1:0]              claim_hit;

  region_e                       region;
  logic [IDX_W-1:0]              idx;
  logic [REG_W-1:0]              rd_val;

  assign region = region_e'(cfg_addr[8:7]);
  assign idx    = cfg_addr[6:2];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (cfg_wr) begin
      case (region)
        RG_PRIO: for (int i = 1; i <= N_SRC; i++)
                   if (idx == IDX_W'(i)) prio_q[i] <= cfg_wdata[PRIO_W-1:0];
        RG_EN:   for (int t = 0; t < N_TGT; t++)
                   if (idx == IDX_W'(t)) en_q[t] <= {cfg_wdata[N_SRC:1], 1'b0};
        RG_THR:  for (int t = 0; t < N_TGT; t++)
                   if (idx == IDX_W'(t)) thr_q[t] <= cfg_wdata[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (region)
      RG_PRIO: for (int i = 1; i <= N_SRC; i++)
                 if (idx == IDX_W'(i)) rd_val[PRIO_W-1:0] = prio_q[i];
      RG_PEND: rd_val[N_SRC:0] = pend;
      RG_EN:   for (int t = 0; t < N_TGT; t++)
                 if (idx == IDX_W'(t)) rd_val[N_SRC:0] = en_q[t];
      RG_THR:  for (int t = 0; t < N_TGT; t++)
                 if (idx == IDX_W'(t)) rd_val[PRIO_W-1:0] = thr_q[t];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_val;
  end

  // valid completions: only sources currently in service
  always_comb begin
    logic [ID_W-1:0] wid;
    done = '0;
    for (int t = 0; t < N_TGT; t++) begin
      wid = clm_wid[t*ID_W +: ID_W];
      if (clm_wr[t])
        for (int i = 1; i <= N_SRC; i++)
          if ((wid == ID_W'(i)) && busy[i]) done[i] = 1'b1;
    end
  end

  irq_src_state #(.N_SRC(N_SRC)) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (irq_i),
    .take  (take),
    .done  (done),
    .pend  (pend),
    .busy  (busy)
  );

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    irq_target_sel #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
      .pend    (pend),
      .en      (en_q[t]),
      .prio    (prio_q),
      .thr     (thr_q[t]),
      .best_id (best_flat[t*ID_W +: ID_W])
    );
    assign tgt_irq[t]   = (best_flat[t*ID_W +: ID_W] != '0);
    assign claim_hit[t] = (grant_flat[t*ID_W +: ID_W] != '0);
  end

  irq_claim_arb #(.N_SRC(N_SRC), .N_TGT(N_TGT), .ID_W(ID_W)) u_arb (
    .best_flat  (best_flat),
    .clm_rd     (clm_rd),
    .grant_flat (grant_flat),
    .take       (take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) clm_rid <= '0;
    else        clm_rid <= grant_flat;
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_SRC = 31,
  parameter int N_TGT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC:0]   pend,
  input logic [N_SRC:0]   busy,
  input logic [N_SRC:0]   take,
  input logic [N_SRC:0]   done,
  input logic [N_TGT-1:0] claim_hit,
  input logic [N_TGT-1:0] tgt_irq
);
  AST_PEND_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & busy) == '0); // R7

  AST_GRANT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(take) == $countones(claim_hit)); // R6

  AST_TAKE_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (take & ~pend) == '0); // R5

  AST_TAKE_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (take != '0) |=> (((busy & $past(take)) == $past(take)) && ((pend & $past(take)) == '0))); // R5

  AST_BUSY_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(busy) & ~busy) & ~$past(done)) == '0)); // R8

  AST_IRQ_HAS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_irq != '0) |-> (pend != '0)); // R3
endmodule

bind irq_router irq_router_chk #(.N_SRC(N_SRC), .N_TGT(N_TGT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend      (pend),
  .busy      (busy),
  .take      (take),
  .done      (done),
  .claim_hit (claim_hit),
  .tgt_irq   (tgt_irq)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  localparam int N_SRC  = 31;
  localparam int N_TGT  = 2;
  localparam int PRIO_W = 3;
  localparam int ID_W   = 5;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [N_SRC-1:0]      irq_i = '0;
  logic                  cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [8:0]            cfg_addr = '0;
  logic [31:0]           cfg_wdata = '0;
  logic [31:0]           cfg_rdata;
  logic [N_TGT-1:0]      clm_rd = '0, clm_wr = '0;
  logic [N_TGT*ID_W-1:0] clm_wid = '0;
  logic [N_TGT*ID_W-1:0] clm_rid;
  logic [N_TGT-1:0]      tgt_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_router #(.N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W)) dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .clm_rd(clm_rd), .clm_wr(clm_wr), .clm_wid(clm_wid),
    .clm_rid(clm_rid), .tgt_irq(tgt_irq)
  );

  // address helpers written from the R2 map
  function automatic logic [8:0] a_prio(int k); return 9'(4 * k);         endfunction
  function automatic logic [8:0] a_pend();      return 9'h080;            endfunction
  function automatic logic [8:0] a_en(int t);   return 9'(9'h100 + 4*t);  endfunction
  function automatic logic [8:0] a_thr(int t);  return 9'(9'h180 + 4*t);  endfunction
  function automatic logic [31:0] sbit(int k);  return 32'h1 << k;        endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_i = '0; cfg_wr = 0; cfg_rd = 0; clm_rd = '0; clm_wr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_addr = a;
    @(posedge clk); #1;
    d = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic claim(input int t, output logic [31:0] id);
    @(negedge clk);
    clm_rd[t] = 1'b1;
    @(posedge clk); #1;
    id = 32'(clm_rid[t*ID_W +: ID_W]);
    @(negedge clk);
    clm_rd[t] = 1'b0;
  endtask

  task automatic complete(input int t, input int id);
    @(negedge clk);
    clm_wr[t] = 1'b1; clm_wid[t*ID_W +: ID_W] = ID_W'(id);
    @(negedge clk);
    clm_wr[t] = 1'b0;
  endtask

  task automatic raise(input int k);
    @(negedge clk);
    irq_i[k-1] = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    @(posedge clk); #1;
    chk("R1 irq low", 32'(tgt_irq), 0);
    rd(a_pend(), v);    chk("R1 pending zero", v, 0);
    rd(a_prio(1), v);   chk("R1 prio zero", v, 0);
    claim(0, v);        chk("R1 empty claim", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    do_reset();
    wr(a_prio(3), 32'hFF);       rd(a_prio(3), v);  chk("R2 prio masked", v, 7);
    wr(a_en(1), 32'hFFFF_FFFF);  rd(a_en(1), v);    chk("R2 enable bit0", v, 32'hFFFF_FFFE);
    wr(a_thr(0), 32'h15);        rd(a_thr(0), v);   chk("R2 thr masked", v, 5);
    rd(a_en(0), v);                                 chk("R2 other enable", v, 0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    do_reset();
    wr(a_prio(4), 3); wr(a_en(0), sbit(4)); wr(a_thr(0), 3);
    raise(4);
    rd(a_pend(), v);               chk("R3 pending set", v, sbit(4));
    chk("R3 equal thr blocks", 32'(tgt_irq[0]), 0);
    wr(a_thr(0), 2); #1;
    chk("R3 above thr", 32'(tgt_irq[0]), 1);
    chk("R4 not enabled t1", 32'(tgt_irq[1]), 0);
    wr(a_en(1), sbit(4)); #1;
    chk("R4 enabled t1", 32'(tgt_irq[1]), 1);
    wr(a_en(1), 0); #1;
    chk("R4 masked t1", 32'(tgt_irq[1]), 0);
    chk("R4 t0 unaffected", 32'(tgt_irq[0]), 1);
    // claim, then hold request high
    claim(0, v);                   chk("R5 claim id", v, 4);
    rd(a_pend(), v);               chk("R5 pending cleared", v, 0);
    chk("R5 irq dropped", 32'(tgt_irq), 0);
    claim(0, v);                   chk("R5 claim again empty", v, 0);
    repeat (3) @(negedge clk);
    rd(a_pend(), v);               chk("R7 held not repend", v, 0);
    complete(0, 4);
    @(posedge clk); #1;
    rd(a_pend(), v);               chk("R7 repend after done", v, sbit(4));
  endtask

  task automatic t_stray();
    logic [31:0] v;
    do_reset();
    wr(a_prio(5), 2); wr(a_en(0), sbit(5));
    raise(5);
    claim(0, v);                   chk("R8 setup claim", v, 5);
    complete(0, 6); complete(0, 0); complete(1, 31);
    repeat (2) @(negedge clk);
    rd(a_pend(), v);               chk("R8 stray completes ignored", v, 0);
    chk("R8 irq low", 32'(tgt_irq), 0);
    complete(1, 5);
    @(posedge clk); #1;
    rd(a_pend(), v);               chk("R8 real complete", v, sbit(5));
  endtask

  task automatic t_order();
    logic [31:0] v;
    do_reset();
    wr(a_prio(2), 2); wr(a_prio(7), 5); wr(a_prio(9), 5); wr(a_prio(3), 1);
    wr(a_en(0), 32'hFFFF_FFFE);
    @(negedge clk);
    irq_i[1] = 1; irq_i[2] = 1; irq_i[6] = 1; irq_i[8] = 1;
    @(negedge clk); irq_i = '0;
    claim(0, v); chk("R9 highest then lowest id", v, 7);
    claim(0, v); chk("R9 tie second", v, 9);
    claim(0, v); chk("R9 next prio", v, 2);
    claim(0, v); chk("R9 last", v, 3);
    claim(0, v); chk("R9 drained", v, 0);
  endtask

  task automatic t_simul();
    logic [31:0] v0, v1;
    do_reset();
    wr(a_prio(6), 1); wr(a_en(0), sbit(6)); wr(a_en(1), sbit(6));
    raise(6);
    @(negedge clk);
    clm_rd = 2'b11;
    @(posedge clk); #1;
    v0 = 32'(clm_rid[0 +: ID_W]);
    v1 = 32'(clm_rid[ID_W +: ID_W]);
    @(negedge clk);
    clm_rd = '0;
    chk("R6 target0 wins", v0, 6);
    chk("R6 target1 zero", v1, 0);
  endtask

  task automatic t_zero_prio();
    logic [31:0] v;
    do_reset();
    wr(a_en(0), sbit(10));
    raise(10);
    chk("R10 no irq", 32'(tgt_irq[0]), 0);
    rd(a_pend(), v);   chk("R10 pending", v, sbit(10));
    claim(0, v);       chk("R10 claim zero", v, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_gate();
    t_stray();
    t_order();
    t_simul();
    t_zero_prio();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule